// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This core is a small Harvard-style processor. It holds an 8-bit accumulator, a carry flag, an immediate-pairing flag and eight 8-bit data registers internally. Program memory lives outside the core. Each clock cycle the core reads one 6-bit instruction from a dedicated input bus and completes it in that same cycle. There is no multi-cycle sequencing. The top two instruction bits select a class: register move, arithmetic/miscellaneous, immediate, or branch. The low four bits carry a register index, a nibble constant or a signed branch offset.

A single 8-bit output bus is shared by time. While the clock is high it carries the program counter, so external memory can use it to fetch the next instruction. While the clock is low it carries the accumulator. An OUT instruction raises a one-cycle strobe on a separate port, together with the value of the accumulator.

A parameter `EXT` selects an extended mode, which changes three things:
- NEG also writes the carry flag.
- A branch that directly follows a first immediate takes its upper target bits from the accumulator.
- The accumulator jump becomes a no-op.

Top module: `acc8_core`

## Requirements
- R1: While `rst_n` is low, and after it rises, the program counter, accumulator, carry and immediate flag are all zero and `out_valid` is 0. Reset is asynchronous.
- R2: `bus_out` shows the program counter while `clk` is 1 and the accumulator while `clk` is 0.
- R3: Immediate `10nnnn`.
  - With the immediate flag clear, the accumulator becomes the sign-extended nibble `nnnn` and the flag is set.
  - With the flag set, the accumulator becomes `{acc[3:0], nnnn}` and the flag is cleared.
  - Every non-immediate instruction clears the flag.
- R4: Register moves.
  - `000rrr` loads register `rrr` into the accumulator.
  - `001rrr` stores the accumulator into register `rrr` and leaves the accumulator unchanged.
  - Each register keeps its own value.
- R5: `010rrr` adds register `rrr` to the accumulator modulo 256. The carry takes bit 8 of the sum, so it is set on overflow and cleared otherwise.
- R6: Complement and negate.
  - `011000` replaces the accumulator with its bitwise complement.
  - `011001` replaces it with its two's complement.
  - In the base mode, negate leaves the carry unchanged.
- R7: Branch `11oooo`.
  - With the carry clear, the program counter becomes the branch's own address plus the sign-extended `oooo`.
  - With the carry set, the branch falls through to the next address and clears the carry.
- R8: `011011` in the base mode loads the program counter from the accumulator. In the extended mode it is a no-op.
- R9: `011010` (OUT) leaves the state unchanged apart from the program counter. In the next cycle it drives `out_valid` to 1 for one cycle, with `out_data` equal to the accumulator of the OUT cycle.
- R10: In the extended mode, negate sets the carry when the accumulator was zero and clears it otherwise.
- R11: In the extended mode, a taken branch issued while the immediate flag is set jumps to `{acc[3:0], oooo}`.
- R12: Every instruction that is not a taken branch or a jump advances the program counter by one. Codes `0111xx` are no-ops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Its level also selects what `bus_out` shows |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 6 | Instruction fetched from external program memory |
| bus_out | output | 8 | Program counter while clk is high, accumulator while clk is low |
| out_valid | output | 1 | One-cycle strobe in the cycle after an OUT |
| out_data | output | 8 | Accumulator value captured by OUT |

## Verification
Two functions can fall in the same cycle, and both cases are provoked with back-to-back instructions.

The first case is a branch that reads the carry while also clearing it. A not-taken branch is placed directly after an overflowing ADD, and then after a negate of zero in the extended mode. The branch must fall through, and the second branch of the pair must then be taken.

The second case is a branch that consumes the immediate flag set by the instruction just before it. A first immediate is issued directly before a branch. The base core must take the relative target while the extended core takes the accumulator-nibble target. The two cores are driven with the same stream and compared through their program counters on the high clock phase.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW = 8;
  localparam int IW = 6;
  localparam int FW = 4;

  typedef enum logic [3:0] {
    OP_NOP, OP_LDA, OP_STA, OP_ADD, OP_NOT,
    OP_NEG, OP_OUT, OP_JMPA, OP_LDI, OP_BCC
  } op_e;

  // nibble -> data width, sign extended
  function automatic logic [DW-1:0] sext_nib(input logic [FW-1:0] n);
    return {{(DW-FW){n[FW-1]}}, n};
  endfunction

  // {carry, sum}
  function automatic logic [DW:0] add_c(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // {carry, result}: carry out of (~a + 1), set only for a == 0
  function automatic logic [DW:0] neg_c(input logic [DW-1:0] a);
    return {1'b0, ~a} + {{DW{1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] rel_target(input logic [DW-1:0] pc,
                                               input logic [FW-1:0] off);
    return pc + sext_nib(off);
  endfunction
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
#(
  parameter bit EXT  = 1'b0,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [IW-1:0] instr,
  output op_e           op,
  output logic [RW-1:0] ridx,
  output logic [FW-1:0] fld
);
  assign ridx = instr[RW-1:0];
  assign fld  = instr[FW-1:0];

  always_comb begin
    op = OP_NOP;
    unique case (instr[5:4])
      2'b00: op = instr[3] ? OP_STA : OP_LDA;
      2'b01: begin
        if (!instr[3]) op = OP_ADD;
        else begin
          case (instr[2:0])
            3'd0:    op = OP_NOT;
            3'd1:    op = OP_NEG;
            3'd2:    op = OP_OUT;
            3'd3:    op = EXT ? OP_NOP : OP_JMPA;
            default: op = OP_NOP;
          endcase
        end
      end
      2'b10: op = OP_LDI;
      2'b11: op = OP_BCC;
      default: op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile
  import acc8_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[g] <= '0;
      else if (we && addr == RW'(g))      mem[g] <= wdata;
    end
  end

  // single port: the read uses the same address as the write
  assign rdata = mem[addr];
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rdata,
  input  logic [FW-1:0] fld,
  input  logic          carry,
  input  logic          iflag,
  output logic [DW-1:0] acc_nxt,
  output logic          carry_nxt,
  output logic          iflag_nxt,
  output logic          reg_we
);
  logic [DW:0] sum, neg;
  assign sum = add_c(acc, rdata);
  assign neg = neg_c(acc);

  always_comb begin
    acc_nxt   = acc;
    carry_nxt = carry;
    iflag_nxt = 1'b0;
    reg_we    = 1'b0;
    case (op)
      OP_LDA: acc_nxt = rdata;
      OP_STA: reg_we  = 1'b1;
      OP_ADD: {carry_nxt, acc_nxt} = sum;
      OP_NOT: acc_nxt = ~acc;
      OP_NEG: begin
        acc_nxt = neg[DW-1:0];
        if (EXT) carry_nxt = neg[DW];
      end
      OP_LDI: begin
        if (iflag) acc_nxt = {acc[FW-1:0], fld};
        else       acc_nxt = sext_nib(fld);
        iflag_nxt = !iflag;
      end
      OP_BCC: carry_nxt = 1'b0;  // taken needs carry clear; not taken clears it
      default: ;
    endcase
  end
endmodule

// File: rtl/acc8_pcu.sv
module acc8_pcu
  import acc8_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  op_e           op,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] acc,
  input  logic [FW-1:0] fld,
  input  logic          carry,
  input  logic          iflag,
  output logic [DW-1:0] pc_nxt,
  output logic          br_taken
);
  assign br_taken = (op == OP_BCC) && !carry;

  always_comb begin
    pc_nxt = pc + 1'b1;
    if (br_taken) begin
      if (EXT && iflag) pc_nxt = {acc[FW-1:0], fld};
      else              pc_nxt = rel_target(pc, fld);
    end else if (op == OP_JMPA) begin
      pc_nxt = acc;
    end
  end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter bit EXT  = 1'b0,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  output logic [DW-1:0] bus_out,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] pc_q, acc_q;
  logic          carry_q, iflag_q;

  op_e           dec_op;
  logic [RW-1:0] dec_ridx;
  logic [FW-1:0] dec_fld;
  logic [DW-1:0] rf_rdata, acc_nxt, pc_nxt;
  logic          carry_nxt, iflag_nxt, rf_we, br_taken;

  // named events for the checks below
  logic ev_out, ev_sta, ev_bcc, ev_ldi, ev_jump;
  assign ev_out  = (dec_op == OP_OUT);
  assign ev_sta  = (dec_op == OP_STA);
  assign ev_bcc  = (dec_op == OP_BCC);
  assign ev_ldi  = (dec_op == OP_LDI);
  assign ev_jump = br_taken || (dec_op == OP_JMPA);

  acc8_decode #(.EXT(EXT), .NREG(NREG)) u_dec (
    .instr(instr), .op(dec_op), .ridx(dec_ridx), .fld(dec_fld)
  );

  acc8_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .addr(dec_ridx), .we(rf_we),
    .wdata(acc_q), .rdata(rf_rdata)
  );

  acc8_alu #(.EXT(EXT)) u_alu (
    .op(dec_op), .acc(acc_q), .rdata(rf_rdata), .fld(dec_fld),
    .carry(carry_q), .iflag(iflag_q), .acc_nxt(acc_nxt),
    .carry_nxt(carry_nxt), .iflag_nxt(iflag_nxt), .reg_we(rf_we)
  );

  acc8_pcu #(.EXT(EXT)) u_pcu (
    .op(dec_op), .pc(pc_q), .acc(acc_q), .fld(dec_fld), .carry(carry_q),
    .iflag(iflag_q), .pc_nxt(pc_nxt), .br_taken(br_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      acc_q     <= '0;
      carry_q   <= 1'b0;
      iflag_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      pc_q      <= pc_nxt;
      acc_q     <= acc_nxt;
      carry_q   <= carry_nxt;
      iflag_q   <= iflag_nxt;
      out_valid <= ev_out;
      if (ev_out) out_data <= acc_q;
    end
  end

  // clock-phase multiplexed output
  assign bus_out = clk ? pc_q : acc_q;

  // R9: OUT strobes next cycle with the accumulator it saw
  p_out_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out |=> out_valid && out_data == $past(acc_q));

  // R4: a store leaves the accumulator alone
  p_store_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sta |=> acc_q == $past(acc_q));

  // R7: a branch never leaves the carry set
  p_branch_clears_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bcc |=> !carry_q);

  // R3: the pairing flag survives only across an immediate
  p_iflag_only_ldi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ldi |=> !iflag_q);

  // R12: sequential instructions step the counter by one
  p_pc_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_jump |=> pc_q == $past(pc_q) + 8'd1);
endmodule

// File: tb/acc8_core_bench.sv
module acc8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] instr = 6'h1C;
  logic [7:0] bus_b, bus_x, od_b, od_x;
  logic       ov_b, ov_x;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  acc8_core #(.EXT(1'b0)) u_acc8_core (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .bus_out(bus_b), .out_valid(ov_b), .out_data(od_b)
  );
  acc8_core #(.EXT(1'b1)) u_acc8_core_x (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .bus_out(bus_x), .out_valid(ov_x), .out_data(od_x)
  );

  function automatic string rname(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // drive one instruction to both cores; check PC (clk high), ACC (clk low)
  task automatic step(input string tag, input logic [5:0] ins,
                      input logic [7:0] pcb, input logic [7:0] accb,
                      input logic [7:0] pcx, input logic [7:0] accx);
    bit is_out;
    is_out = (ins == 6'h1A);
    instr = ins;
    @(posedge clk); #2;
    chk(tag, "pc base", bus_b, pcb);
    chk(tag, "pc ext",  bus_x, pcx);
    chk(tag, "out_valid base", {7'd0, ov_b}, {7'd0, is_out});
    chk(tag, "out_valid ext",  {7'd0, ov_x}, {7'd0, is_out});
    if (is_out) begin
      chk("R9", "out_data base", od_b, accb);
      chk("R9", "out_data ext",  od_x, accx);
    end
    @(negedge clk); #2;
    chk(tag, "acc base", bus_b, accb);
    chk(tag, "acc ext",  bus_x, accx);
  endtask

  // {req, instr, pc after, acc after} - both cores share these
  localparam int NV = 26;
  localparam logic [25:0] VEC [NV] = '{
    {4'd3,  6'h25, 8'h01, 8'h05},  // LDI 5 -> sext
    {4'd3,  6'h2A, 8'h02, 8'h5A},  // pair -> 5A
    {4'd4,  6'h08, 8'h03, 8'h5A},  // STA r0
    {4'd3,  6'h2F, 8'h04, 8'hFF},  // LDI F -> FF
    {4'd4,  6'h0F, 8'h05, 8'hFF},  // STA r7
    {4'd3,  6'h21, 8'h06, 8'h01},  // LDI 1
    {4'd5,  6'h17, 8'h07, 8'h00},  // ADD r7 overflow, carry=1
    {4'd7,  6'h33, 8'h08, 8'h00},  // BCC not taken, clears carry
    {4'd7,  6'h32, 8'h0A, 8'h00},  // BCC +2 taken
    {4'd4,  6'h00, 8'h0B, 8'h5A},  // LDA r0
    {4'd5,  6'h10, 8'h0C, 8'hB4},  // ADD r0, no carry
    {4'd6,  6'h18, 8'h0D, 8'h4B},  // NOT
    {4'd6,  6'h19, 8'h0E, 8'hB5},  // NEG
    {4'd5,  6'h17, 8'h0F, 8'hB4},  // ADD r7, carry=1
    {4'd4,  6'h09, 8'h10, 8'hB4},  // STA r1
    {4'd4,  6'h00, 8'h11, 8'h5A},  // LDA r0
    {4'd4,  6'h01, 8'h12, 8'hB4},  // LDA r1
    {4'd7,  6'h3E, 8'h13, 8'hB4},  // BCC -2 not taken
    {4'd7,  6'h3C, 8'h0F, 8'hB4},  // BCC -4 taken
    {4'd3,  6'h20, 8'h10, 8'h00},  // LDI 0
    {4'd3,  6'h23, 8'h11, 8'h03},  // pair -> 03
    {4'd12, 6'h1C, 8'h12, 8'h03},  // no-op
    {4'd9,  6'h1A, 8'h13, 8'h03},  // OUT
    {4'd3,  6'h27, 8'h14, 8'h07},  // LDI 7
    {4'd3,  6'h28, 8'h15, 8'h78},  // pair -> 78
    {4'd3,  6'h28, 8'h16, 8'hF8}   // third LDI restarts: sext 8
  };

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; #2;
    chk("R1", "acc in reset base", bus_b, 8'h00);
    chk("R1", "acc in reset ext",  bus_x, 8'h00);
    @(posedge clk); #2;
    chk("R1", "pc in reset base", bus_b, 8'h00);
    chk("R1", "pc in reset ext",  bus_x, 8'h00);
    chk("R1", "out_valid in reset", {6'd0, ov_b, ov_x}, 8'h00);
    @(negedge clk); rst_n = 1'b1; #2;
  endtask

  initial begin
    instr = 6'h1C;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      step(rname(int'(v[25:22])), v[21:16], v[15:8], v[7:0], v[15:8], v[7:0]);
    end
    // strobe lasts one cycle (R9)
    step("R9", 6'h1C, 8'h17, 8'hF8, 8'h17, 8'hF8);

    // divergent modes
    do_reset();
    step("R3",  6'h24, 8'h01, 8'h04, 8'h01, 8'h04);
    step("R3",  6'h20, 8'h02, 8'h40, 8'h02, 8'h40);
    step("R8",  6'h1B, 8'h40, 8'h40, 8'h03, 8'h40);  // jump vs no-op
    step("R3",  6'h20, 8'h41, 8'h00, 8'h04, 8'h00);
    step("R10", 6'h19, 8'h42, 8'h00, 8'h05, 8'h00);  // NEG 0: ext carry=1
    step("R10", 6'h35, 8'h47, 8'h00, 8'h06, 8'h00);  // base taken, ext falls through
    step("R11", 6'h29, 8'h48, 8'hF9, 8'h07, 8'hF9);  // first LDI sets flag
    step("R11", 6'h33, 8'h4B, 8'hF9, 8'h93, 8'hF9);  // relative vs {acc nib, off}

    // asynchronous reset mid-run, sampled while clk low
    @(negedge clk); #4; rst_n = 1'b0; #2;
    chk("R1", "async acc base", bus_b, 8'h00);
    chk("R1", "async acc ext",  bus_x, 8'h00);
    @(posedge clk); #2;
    chk("R2", "pc phase after reset", bus_b, 8'h00);
    chk("R1", "async pc ext", bus_x, 8'h00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule